// File: doc/BRIEF.md
# Per-Cycle Parameter Frame Sequencer

Once in every machine cycle, at a nominal rate of 60 Hz, a "data valid" event reaches this block. The block then sends a short burst of tagged 32-bit frames that describe the cycle after the next one. These frames carry the following values:

- the start time of that cycle;
- the measured ring revolution frequency;
- the AC line-crossing phase error;
- the selected beam flavour;
- the machine and beam mode.

A final frame closes every burst. It holds a 24-bit CRC over all the data frames of the burst, so a receiver can reject a burst that was corrupted on the way. The frames leave on a plain valid/ready stream, and the sink may stall them.

All parameter inputs are captured together on the clock edge that accepts the trigger. The values in a burst therefore belong together, even if the measurement sources update while the burst is being sent.

When the CRC frame is accepted, the block computes a correction term from a measured link-clock count and publishes it on a register output for the timing reference generator, with a one-cycle write strobe. A trigger that arrives while a burst is still being sent is dropped, and a sticky flag records that this happened.

Top module: `cycle_param_framer`

## Requirements
- R1: After reset, frm_valid_o, busy_o, done_o, overrun_o and corr_wr_o are low and corr_o is zero.
- R2: A high trig_i at a clock edge while busy_o is low starts a burst: from the next cycle busy_o and frm_valid_o are high and the first frame is presented. With no trigger, frm_valid_o stays low.
- R3: A burst is six frames, in this order of tags: 0xA1 start time, 0xA2 revolution frequency, 0xA3 phase error, 0xA4 flavour, 0xA5 mode, 0xAF CRC. In each frame the tag sits in frm_data_o[31:24] and the 24-bit payload in frm_data_o[23:0]. frm_last_o is high only with the CRC frame.
- R4: The payloads of the five data frames are the values on ts_i, rev_freq_i, phase_err_i, flavor_i and mode_i at the edge that started the burst. Later changes on these inputs do not alter the burst.
- R5: A frame advances only on an edge where frm_valid_o and frm_ready_i are both high. While frm_ready_i is low, frm_valid_o and frm_data_o stay unchanged.
- R6: The CRC payload is a CRC-24 over the 20 bytes of the five data frames, taking each frame tag byte first and then the payload bytes from most to least significant. It uses polynomial 0x864CFB, start value 0xB704CE, MSB-first processing, no reflection and no final XOR. The start value is reloaded for every burst.
- R7: A trig_i high while busy_o is high is dropped. This includes the edge that accepts the CRC frame. The current burst continues unchanged, no new burst follows, and overrun_o goes high and stays high until reset.
- R8: On the edge that accepts the CRC frame, busy_o falls. For exactly one cycle, done_o and corr_wr_o are high. corr_o then holds NOMINAL_COUNT (default 555555) minus link_count_i sampled at the trigger edge, modulo 2^24.
- R9: A trigger in the cycle where done_o is high starts a new burst at once, and that burst carries its own, correct CRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Per-cycle data-valid event |
| ts_i | input | 24 | Start time of the described cycle |
| rev_freq_i | input | 24 | Ring revolution frequency |
| phase_err_i | input | 24 | Line-crossing phase error |
| flavor_i | input | 24 | Beam flavour code |
| mode_i | input | 24 | Machine and beam mode |
| link_count_i | input | 24 | Measured link-clock count per cycle |
| frm_ready_i | input | 1 | Sink accepts the current frame |
| frm_valid_o | output | 1 | Frame present on frm_data_o |
| frm_data_o | output | 32 | Tag [31:24] and payload [23:0] |
| frm_last_o | output | 1 | Current frame is the CRC frame |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle pulse at burst end |
| overrun_o | output | 1 | Sticky: a trigger was dropped |
| corr_wr_o | output | 1 | One-cycle write strobe for corr_o |
| corr_o | output | 24 | Timing reference correction term |

## Verification
The hardest case to reach is a trigger that coincides with the edge accepting the CRC frame. At that edge the block is still busy for one more instant, so the trigger must be dropped, even though the very next cycle would have accepted it. The stimulus reaches this case by raising trig_i in the same cycle that it raises frm_ready_i on the final frame. It then checks that overrun_o is set and that no frame follows. It also places a trigger in the done cycle to show that such a trigger is accepted, and mixes random stall patterns and random input changes during bursts to test the capture and the stall-hold behaviour.

// File: rtl/cpf_pkg.sv
package cpf_pkg;

    localparam int TAG_W       = 8;
    localparam int FRAME_CNT   = 6;
    localparam int DATA_FRAMES = FRAME_CNT - 1;
    localparam int IDX_W       = $clog2(FRAME_CNT);

    typedef enum logic [IDX_W-1:0] {
        FR_TS     = 3'd0,
        FR_REV    = 3'd1,
        FR_PHASE  = 3'd2,
        FR_FLAVOR = 3'd3,
        FR_MODE   = 3'd4,
        FR_CRC    = 3'd5
    } frame_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } seq_state_e;

    localparam logic [TAG_W-1:0] TAG_TS     = 8'hA1;
    localparam logic [TAG_W-1:0] TAG_REV    = 8'hA2;
    localparam logic [TAG_W-1:0] TAG_PHASE  = 8'hA3;
    localparam logic [TAG_W-1:0] TAG_FLAVOR = 8'hA4;
    localparam logic [TAG_W-1:0] TAG_MODE   = 8'hA5;
    localparam logic [TAG_W-1:0] TAG_CRC    = 8'hAF;

    function automatic logic [TAG_W-1:0] frame_tag(frame_e f);
        case (f)
            FR_TS:     return TAG_TS;
            FR_REV:    return TAG_REV;
            FR_PHASE:  return TAG_PHASE;
            FR_FLAVOR: return TAG_FLAVOR;
            FR_MODE:   return TAG_MODE;
            default:   return TAG_CRC;
        endcase
    endfunction

endpackage

// File: rtl/cpf_crc_step.sv
// Advances a CRC register over one full data word in a single cycle, MSB first.
module cpf_crc_step #(
    parameter int          CRC_W  = 24,
    parameter int          DATA_W = 32,
    parameter logic [23:0] POLY   = 24'h864CFB
) (
    input  logic [CRC_W-1:0]  crc_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [CRC_W-1:0]  crc_o
);

    logic [CRC_W-1:0] chain [DATA_W+1];
    logic [DATA_W-1:0] fb;

    assign chain[0] = crc_i;

    genvar g;
    generate
        for (g = 0; g < DATA_W; g++) begin : g_bit
            assign fb[g] = chain[g][CRC_W-1] ^ data_i[DATA_W-1-g];
            assign chain[g+1] = {chain[g][CRC_W-2:0], 1'b0} ^ (fb[g] ? POLY[CRC_W-1:0] : '0);
        end
    endgenerate

    assign crc_o = chain[DATA_W];

endmodule

// File: rtl/cpf_snapshot.sv
// Captures every parameter and the correction term on one edge.
module cpf_snapshot
    import cpf_pkg::*;
#(
    parameter int PAYLOAD_W     = 24,
    parameter int NOMINAL_COUNT = 555555
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   cap_i,
    input  logic [PAYLOAD_W-1:0]                   ts_i,
    input  logic [PAYLOAD_W-1:0]                   rev_freq_i,
    input  logic [PAYLOAD_W-1:0]                   phase_err_i,
    input  logic [PAYLOAD_W-1:0]                   flavor_i,
    input  logic [PAYLOAD_W-1:0]                   mode_i,
    input  logic [PAYLOAD_W-1:0]                   link_count_i,
    output logic [DATA_FRAMES-1:0][PAYLOAD_W-1:0]  par_o,
    output logic [PAYLOAD_W-1:0]                   corr_o
);

    localparam logic [PAYLOAD_W-1:0] NOM = PAYLOAD_W'(NOMINAL_COUNT);

    typedef struct packed {
        logic [DATA_FRAMES-1:0][PAYLOAD_W-1:0] par;
        logic [PAYLOAD_W-1:0]                  corr;
    } snap_t;

    snap_t snap_d, snap_q;

    always_comb begin
        snap_d = snap_q;
        if (cap_i) begin
            snap_d.par[FR_TS]     = ts_i;
            snap_d.par[FR_REV]    = rev_freq_i;
            snap_d.par[FR_PHASE]  = phase_err_i;
            snap_d.par[FR_FLAVOR] = flavor_i;
            snap_d.par[FR_MODE]   = mode_i;
            snap_d.corr           = NOM - link_count_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) snap_q <= '0;
        else        snap_q <= snap_d;
    end

    assign par_o  = snap_q.par;
    assign corr_o = snap_q.corr;

    AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_i |=> $stable(snap_q)); // R4

endmodule

// File: rtl/cpf_frame_sel.sv
// Builds the outgoing word for the frame index in flight.
module cpf_frame_sel
    import cpf_pkg::*;
#(
    parameter int PAYLOAD_W = 24
) (
    input  frame_e                                idx_i,
    input  logic [DATA_FRAMES-1:0][PAYLOAD_W-1:0] par_i,
    input  logic [PAYLOAD_W-1:0]                  crc_i,
    output logic [TAG_W+PAYLOAD_W-1:0]            word_o,
    output logic                                  last_o
);

    logic [PAYLOAD_W-1:0] payload;

    always_comb begin
        case (idx_i)
            FR_TS:     payload = par_i[FR_TS];
            FR_REV:    payload = par_i[FR_REV];
            FR_PHASE:  payload = par_i[FR_PHASE];
            FR_FLAVOR: payload = par_i[FR_FLAVOR];
            FR_MODE:   payload = par_i[FR_MODE];
            default:   payload = crc_i;
        endcase
    end

    assign word_o = {frame_tag(idx_i), payload};
    assign last_o = (idx_i == FR_CRC);

endmodule

// File: rtl/cycle_param_framer.sv
module cycle_param_framer
    import cpf_pkg::*;
#(
    parameter int          PAYLOAD_W     = 24,
    parameter logic [23:0] CRC_POLY      = 24'h864CFB,
    parameter logic [23:0] CRC_INIT      = 24'hB704CE,
    parameter int          NOMINAL_COUNT = 555555
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         trig_i,
    input  logic [PAYLOAD_W-1:0]         ts_i,
    input  logic [PAYLOAD_W-1:0]         rev_freq_i,
    input  logic [PAYLOAD_W-1:0]         phase_err_i,
    input  logic [PAYLOAD_W-1:0]         flavor_i,
    input  logic [PAYLOAD_W-1:0]         mode_i,
    input  logic [PAYLOAD_W-1:0]         link_count_i,
    input  logic                         frm_ready_i,
    output logic                         frm_valid_o,
    output logic [TAG_W+PAYLOAD_W-1:0]   frm_data_o,
    output logic                         frm_last_o,
    output logic                         busy_o,
    output logic                         done_o,
    output logic                         overrun_o,
    output logic                         corr_wr_o,
    output logic [PAYLOAD_W-1:0]         corr_o
);

    localparam int CRC_W  = PAYLOAD_W;
    localparam int WORD_W = TAG_W + PAYLOAD_W;

    typedef struct packed {
        seq_state_e           st;
        frame_e               idx;
        logic [CRC_W-1:0]     crc;
        logic                 done;
        logic                 ovr;
        logic                 corr_wr;
        logic [PAYLOAD_W-1:0] corr;
    } seq_t;

    seq_t seq_d, seq_q;

    logic                                  capture;
    logic [DATA_FRAMES-1:0][PAYLOAD_W-1:0] par;
    logic [PAYLOAD_W-1:0]                  snap_corr;
    logic [CRC_W-1:0]                      crc_next;
    logic [WORD_W-1:0]                     word;
    logic                                  last;

    cpf_snapshot #(
        .PAYLOAD_W     (PAYLOAD_W),
        .NOMINAL_COUNT (NOMINAL_COUNT)
    ) u_snap (
        .clk          (clk),
        .rst_n        (rst_n),
        .cap_i        (capture),
        .ts_i         (ts_i),
        .rev_freq_i   (rev_freq_i),
        .phase_err_i  (phase_err_i),
        .flavor_i     (flavor_i),
        .mode_i       (mode_i),
        .link_count_i (link_count_i),
        .par_o        (par),
        .corr_o       (snap_corr)
    );

    cpf_frame_sel #(
        .PAYLOAD_W (PAYLOAD_W)
    ) u_sel (
        .idx_i  (seq_q.idx),
        .par_i  (par),
        .crc_i  (seq_q.crc),
        .word_o (word),
        .last_o (last)
    );

    cpf_crc_step #(
        .CRC_W  (CRC_W),
        .DATA_W (WORD_W),
        .POLY   (CRC_POLY)
    ) u_crc (
        .crc_i  (seq_q.crc),
        .data_i (word),
        .crc_o  (crc_next)
    );

    always_comb begin
        seq_d         = seq_q;
        seq_d.done    = 1'b0;
        seq_d.corr_wr = 1'b0;
        capture       = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (trig_i) begin
                    seq_d.st  = ST_SEND;
                    seq_d.idx = FR_TS;
                    seq_d.crc = CRC_INIT[CRC_W-1:0];
                    capture   = 1'b1;
                end
            end
            default: begin
                if (trig_i) seq_d.ovr = 1'b1;
                if (frm_ready_i) begin
                    if (last) begin
                        seq_d.st      = ST_IDLE;
                        seq_d.idx     = FR_TS;
                        seq_d.done    = 1'b1;
                        seq_d.corr_wr = 1'b1;
                        seq_d.corr    = snap_corr;
                    end else begin
                        seq_d.crc = crc_next;
                        seq_d.idx = frame_e'(seq_q.idx + 1'b1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q     <= '0;
            seq_q.st  <= ST_IDLE;
            seq_q.idx <= FR_TS;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign frm_valid_o = (seq_q.st == ST_SEND);
    assign busy_o      = (seq_q.st == ST_SEND);
    assign frm_data_o  = word;
    assign frm_last_o  = frm_valid_o & last;
    assign done_o      = seq_q.done;
    assign overrun_o   = seq_q.ovr;
    assign corr_wr_o   = seq_q.corr_wr;
    assign corr_o      = seq_q.corr;

    AST_START_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && trig_i) |=> (frm_valid_o && frm_data_o[WORD_W-1 -: TAG_W] == TAG_TS)); // R2

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid_o && !frm_ready_i) |=> (frm_valid_o && $stable(frm_data_o))); // R5

    AST_CLOSE_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid_o && frm_ready_i && frm_last_o) |=> (done_o && corr_wr_o && !busy_o)); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8

    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && trig_i) |=> overrun_o); // R7

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o); // R7

endmodule

// File: tb/tb_cycle_param_framer.sv
module tb_cycle_param_framer;

    localparam logic [23:0] POLY = 24'h864CFB;
    localparam logic [23:0] INIT = 24'hB704CE;
    localparam logic [23:0] NOM  = 24'd555555;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig = 1'b0;
    logic [23:0] ts = '0, rev = '0, ph = '0, fl = '0, md = '0, lnk = '0;
    logic        rdy = 1'b0;
    logic        frm_valid_o, frm_last_o, busy_o, done_o, overrun_o, corr_wr_o;
    logic [31:0] frm_data_o;
    logic [23:0] corr_o;

    int checks = 0;
    int fails  = 0;
    bit ovr_exp = 1'b0;

    always #2 clk = ~clk;

    cycle_param_framer dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .trig_i       (trig),
        .ts_i         (ts),
        .rev_freq_i   (rev),
        .phase_err_i  (ph),
        .flavor_i     (fl),
        .mode_i       (md),
        .link_count_i (lnk),
        .frm_ready_i  (rdy),
        .frm_valid_o  (frm_valid_o),
        .frm_data_o   (frm_data_o),
        .frm_last_o   (frm_last_o),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .overrun_o    (overrun_o),
        .corr_wr_o    (corr_wr_o),
        .corr_o       (corr_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    function automatic logic [23:0] crc_byte(input logic [23:0] c, input logic [7:0] b);
        logic [23:0] r;
        r = c ^ {b, 16'h0000};
        for (int i = 0; i < 8; i++) r = r[23] ? ((r << 1) ^ POLY) : (r << 1);
        return r;
    endfunction

    // Entered at a negedge with the design idle; leaves at the negedge after the done cycle check.
    task automatic burst(input logic [23:0] p0, input logic [23:0] p1, input logic [23:0] p2,
                         input logic [23:0] p3, input logic [23:0] p4, input logic [23:0] link,
                         input int stall_pct, input bit mid_trig, input bit last_trig);
        logic [7:0]  tags [6];
        logic [23:0] pv [5];
        logic [31:0] w [6];
        logic [23:0] c;
        int k;
        tags = '{8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'hAF};
        pv   = '{p0, p1, p2, p3, p4};
        c    = INIT;
        for (int f = 0; f < 5; f++) begin
            w[f] = {tags[f], pv[f]};
            for (int b = 0; b < 4; b++) c = crc_byte(c, w[f][31-8*b -: 8]);
        end
        w[5] = {8'hAF, c};
        ts = p0; rev = p1; ph = p2; fl = p3; md = p4; lnk = link;
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        ts = $urandom; rev = $urandom; ph = $urandom; fl = $urandom; md = $urandom; lnk = $urandom;
        chk("R2", {31'b0, busy_o}, 32'd1, "busy after trigger");
        k = 0;
        while (k < 6) begin
            chk("R3", {31'b0, frm_valid_o}, 32'd1, "valid in burst");
            chk(k == 5 ? "R6" : "R4", frm_data_o, w[k], "frame word");
            chk("R3", {31'b0, frm_last_o}, {31'b0, k == 5}, "last flag");
            rdy = (($urandom % 100) >= stall_pct);
            if (mid_trig && k == 2) begin trig = 1'b1; ovr_exp = 1'b1; end
            if (last_trig && k == 5 && rdy) begin trig = 1'b1; ovr_exp = 1'b1; end
            @(negedge clk);
            trig = 1'b0;
            ts = $urandom; md = $urandom;
            if (rdy) k++;
        end
        rdy = 1'b0;
        chk("R8", {31'b0, done_o}, 32'd1, "done pulse");
        chk("R8", {31'b0, corr_wr_o}, 32'd1, "corr write strobe");
        chk("R8", {8'h0, corr_o}, {8'h0, NOM - link}, "correction value");
        chk("R8", {31'b0, busy_o}, 32'd0, "busy released");
        chk("R7", {31'b0, overrun_o}, {31'b0, ovr_exp}, "overrun flag");
        if (last_trig) begin
            @(negedge clk);
            chk("R7", {31'b0, frm_valid_o}, 32'd0, "trigger at final accept started nothing");
            chk("R8", {31'b0, done_o}, 32'd0, "done lasts one cycle");
            chk("R8", {31'b0, corr_wr_o}, 32'd0, "strobe lasts one cycle");
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {31'b0, frm_valid_o}, 32'd0, "valid after reset");
        chk("R1", {31'b0, busy_o}, 32'd0, "busy after reset");
        chk("R1", {31'b0, done_o}, 32'd0, "done after reset");
        chk("R1", {31'b0, overrun_o}, 32'd0, "overrun after reset");
        chk("R1", {31'b0, corr_wr_o}, 32'd0, "strobe after reset");
        chk("R1", {8'h0, corr_o}, 32'd0, "corr after reset");
        repeat (4) begin
            @(negedge clk);
            chk("R2", {31'b0, frm_valid_o}, 32'd0, "no frame without trigger");
        end
        // directed corners
        burst(24'h0, 24'h0, 24'h0, 24'h0, 24'h0, 24'h0, 0, 1'b0, 1'b0);
        @(negedge clk);
        burst(24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 60, 1'b0, 1'b0);
        // R9: trigger in done cycle, back to back
        burst(24'h123456, 24'h00ABCD, 24'h800001, 24'h000005, 24'h000312, 24'd555000, 0, 1'b0, 1'b0);
        burst(24'h654321, 24'h00ABCE, 24'h7FFFFF, 24'h000008, 24'h000207, 24'd556000, 30, 1'b0, 1'b0);
        // random bursts, no overrun yet
        for (int i = 0; i < 20; i++) begin
            burst($urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom % 70, 1'b0, 1'b0);
            repeat ($urandom % 3) @(negedge clk);
        end
        // R7: trigger mid-burst and at final accept
        burst($urandom, $urandom, $urandom, $urandom, $urandom, $urandom, 40, 1'b1, 1'b0);
        @(negedge clk);
        burst($urandom, $urandom, $urandom, $urandom, $urandom, $urandom, 0, 1'b0, 1'b1);
        for (int i = 0; i < 10; i++) begin
            burst($urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom % 50, 1'b0, 1'b0);
        end
        // R1: reset clears the sticky flag
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {31'b0, overrun_o}, 32'd0, "overrun cleared by reset");
        summary();
        $finish;
    end

endmodule